// File: doc/BRIEF.md
# Address-Collision Busy Arbiter

This block sits beside a two-port memory array and watches for a collision: both ports selected (active-low selects low) and presenting the same address in the same cycle. When that happens it decides which of the two ports reached the address first. It then marks the other port busy, and that port's writes are internally inhibited. Arrival order comes from a synchronous model. Each port's select and address are registered every cycle, and a port counts as newly arrived in any cycle where either of them differs from the registered copy. When only one port moved, that port is the late one. When both moved in the same cycle, the left port wins.

The decision is taken in the cycle the collision appears. It is held while the collision persists with no input movement. It is dropped in the same cycle that the addresses part or either port is deselected.

A mode strap selects between two modes. In arbiter mode the block actively drives both busy lines high or low, with a per-side drive enable for a push-pull pad. In follower mode the drive enables are off, the busy outputs sit high, and each side's write inhibit simply follows that side's active-low busy input from an external arbiter.

Top module: `clash_arbiter`

## Requirements
- R1: In arbiter mode (slave_mode_i = 0), both l_busy_no and r_busy_no are 1 whenever l_cs_ni or r_cs_ni is 1, or l_addr_i differs from r_addr_i.
- R2: In arbiter mode, when a collision (both selects 0, equal addresses) appears in a cycle where exactly one port's select or address differs from its value in the previous cycle, that port's busy output goes to 0 in the same cycle and the other port's busy output stays 1.
- R3: In arbiter mode, when a collision appears in a cycle where both ports' inputs changed, r_busy_no is 0 and l_busy_no is 1.
- R4: l_busy_no and r_busy_no are never 0 together.
- R5: While a collision persists with no change on either port's select or address, the busy outputs keep their values. They return to 1 in the first cycle the collision ends.
- R6: In arbiter mode, l_busy_oe_o and r_busy_oe_o are both 1 (busy lines driven at both levels).
- R7: In arbiter mode, each side's write inhibit (l_wr_block_o, r_wr_block_o) is 1 exactly when that side's busy output is 0, whatever the level on the busy inputs.
- R8: In follower mode (slave_mode_i = 1), both busy outputs are 1, both drive enables are 0, and l_wr_block_o = ~l_busy_ni and r_wr_block_o = ~r_busy_ni, independent of any collision.
- R9: Reset leaves the registered port state deselected. A collision present on both ports out of reset is therefore resolved as a same-cycle arrival (right port busy). With no collision, reset gives both busy outputs 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_mode_i | input | 1 | Mode strap: 0 arbiter, 1 follower |
| l_cs_ni | input | 1 | Left port select, active low |
| l_addr_i | input | ADDR_W | Left port address |
| r_cs_ni | input | 1 | Right port select, active low |
| r_addr_i | input | ADDR_W | Right port address |
| l_busy_ni | input | 1 | Left busy input from external arbiter (follower mode) |
| r_busy_ni | input | 1 | Right busy input from external arbiter (follower mode) |
| l_busy_no | output | 1 | Left busy output, active low |
| r_busy_no | output | 1 | Right busy output, active low |
| l_busy_oe_o | output | 1 | Left busy pad drive enable |
| r_busy_oe_o | output | 1 | Right busy pad drive enable |
| l_wr_block_o | output | 1 | Left write inhibit |
| r_wr_block_o | output | 1 | Right write inhibit |

## Verification
A corrupted copy of the registered port state would misjudge which port moved. The error shows in the very cycle a collision forms, as the wrong side going busy. A stale held decision shows only later, on a collision that persists with inputs frozen: the busy line flips although nothing moved. The per-cycle reference model catches both in the cycle they occur. Random traffic over a four-entry address window makes collisions, same-cycle ties and releases frequent.

// File: rtl/clash_arbiter_pkg.sv
package clash_arbiter_pkg;
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/clash_port_tracker.sv
module clash_port_tracker #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              moved_o
);
  logic              cs_q;
  logic [ADDR_W-1:0] addr_q;

  // reset to deselected so a live select counts as an arrival
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      cs_q   <= cs_ni;
      addr_q <= addr_i;
    end
  end

  assign moved_o = (cs_ni != cs_q) || (addr_i != addr_q);
endmodule

// File: rtl/clash_judge.sv
module clash_judge
  import clash_arbiter_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_cs_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_cs_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              l_moved_i,
  input  logic              r_moved_i,
  output logic              l_busy_o,
  output logic              r_busy_o
);
  logic  hit;
  logic  hit_q;
  logic  onset;
  side_e loser_now;
  side_e loser_q;
  side_e loser;

  assign hit   = !l_cs_ni && !r_cs_ni && (l_addr_i == r_addr_i);
  assign onset = hit && (!hit_q || l_moved_i || r_moved_i);

  // the port that moved is late; a tie leaves the right port late
  assign loser_now = r_moved_i ? SIDE_R : (l_moved_i ? SIDE_L : SIDE_R);
  assign loser     = onset ? loser_now : loser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      loser_q <= SIDE_R;
    end else begin
      hit_q   <= hit;
      loser_q <= loser;
    end
  end

  assign l_busy_o = hit && (loser == SIDE_L);
  assign r_busy_o = hit && (loser == SIDE_R);
endmodule

// File: rtl/clash_busy_pad.sv
module clash_busy_pad (
  input  logic slave_mode_i,
  input  logic busy_int_i,
  input  logic busy_ext_ni,
  output logic busy_no,
  output logic busy_oe_o,
  output logic wr_block_o
);
  always_comb begin
    if (slave_mode_i) begin
      busy_no    = 1'b1;
      busy_oe_o  = 1'b0;
      wr_block_o = !busy_ext_ni;
    end else begin
      busy_no    = !busy_int_i;
      busy_oe_o  = 1'b1;
      wr_block_o = busy_int_i;
    end
  end
endmodule

// File: rtl/clash_arbiter.sv
module clash_arbiter
  import clash_arbiter_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_mode_i,
  input  logic              l_cs_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_cs_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              l_busy_ni,
  input  logic              r_busy_ni,
  output logic              l_busy_no,
  output logic              r_busy_no,
  output logic              l_busy_oe_o,
  output logic              r_busy_oe_o,
  output logic              l_wr_block_o,
  output logic              r_wr_block_o
);
  logic [NUM_SIDES-1:0] cs_n;
  logic [ADDR_W-1:0]    addr [NUM_SIDES];
  logic [NUM_SIDES-1:0] moved;
  logic [NUM_SIDES-1:0] busy_int;
  logic [NUM_SIDES-1:0] busy_ext_n;
  logic [NUM_SIDES-1:0] busy_n;
  logic [NUM_SIDES-1:0] busy_oe;
  logic [NUM_SIDES-1:0] wr_block;

  assign cs_n[SIDE_L]       = l_cs_ni;
  assign cs_n[SIDE_R]       = r_cs_ni;
  assign addr[SIDE_L]       = l_addr_i;
  assign addr[SIDE_R]       = r_addr_i;
  assign busy_ext_n[SIDE_L] = l_busy_ni;
  assign busy_ext_n[SIDE_R] = r_busy_ni;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    clash_port_tracker #(.ADDR_W(ADDR_W)) u_track (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cs_ni  (cs_n[s]),
      .addr_i (addr[s]),
      .moved_o(moved[s])
    );

    clash_busy_pad u_pad (
      .slave_mode_i(slave_mode_i),
      .busy_int_i  (busy_int[s]),
      .busy_ext_ni (busy_ext_n[s]),
      .busy_no     (busy_n[s]),
      .busy_oe_o   (busy_oe[s]),
      .wr_block_o  (wr_block[s])
    );
  end

  clash_judge #(.ADDR_W(ADDR_W)) u_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .l_cs_ni  (l_cs_ni),
    .l_addr_i (l_addr_i),
    .r_cs_ni  (r_cs_ni),
    .r_addr_i (r_addr_i),
    .l_moved_i(moved[SIDE_L]),
    .r_moved_i(moved[SIDE_R]),
    .l_busy_o (busy_int[SIDE_L]),
    .r_busy_o (busy_int[SIDE_R])
  );

  assign l_busy_no    = busy_n[SIDE_L];
  assign r_busy_no    = busy_n[SIDE_R];
  assign l_busy_oe_o  = busy_oe[SIDE_L];
  assign r_busy_oe_o  = busy_oe[SIDE_R];
  assign l_wr_block_o = wr_block[SIDE_L];
  assign r_wr_block_o = wr_block[SIDE_R];
endmodule

// File: rtl/clash_arbiter_checker.sv
module clash_arbiter_checker #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slave_mode_i,
  input logic              l_cs_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              r_cs_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              l_busy_ni,
  input logic              r_busy_ni,
  input logic              l_busy_no,
  input logic              r_busy_no,
  input logic              l_busy_oe_o,
  input logic              r_busy_oe_o,
  input logic              l_wr_block_o,
  input logic              r_wr_block_o
);
  logic hit;
  logic warm_q;

  assign hit = !l_cs_ni && !r_cs_ni && (l_addr_i == r_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= 1'b0;
    else         warm_q <= 1'b1;
  end

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && !hit) |-> (l_busy_no && r_busy_no)); // R1

  AST_LEFT_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q && !slave_mode_i && hit && !$past(hit) && $stable(r_cs_ni) && $stable(r_addr_i))
      |-> (!l_busy_no && r_busy_no)); // R2

  AST_RIGHT_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q && !slave_mode_i && hit && !$past(hit) && $stable(l_cs_ni) && $stable(l_addr_i))
      |-> (l_busy_no && !r_busy_no)); // R2

  AST_TIE_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q && !slave_mode_i && hit && !$stable(l_addr_i) && !$stable(r_addr_i))
      |-> (l_busy_no && !r_busy_no)); // R3

  AST_NEVER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_no && !r_busy_no)); // R4

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q && !slave_mode_i && !$past(slave_mode_i) && hit && $stable(l_cs_ni)
     && $stable(l_addr_i) && $stable(r_cs_ni) && $stable(r_addr_i))
      |-> ($stable(l_busy_no) && $stable(r_busy_no))); // R5

  AST_DRIVE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_mode_i |-> (l_busy_oe_o && r_busy_oe_o)); // R6

  AST_BLOCK_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_mode_i |-> ((l_wr_block_o == !l_busy_no) && (r_wr_block_o == !r_busy_no))); // R7

  AST_FOLLOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_mode_i |-> (l_busy_no && r_busy_no && !l_busy_oe_o && !r_busy_oe_o
                      && (l_wr_block_o == !l_busy_ni) && (r_wr_block_o == !r_busy_ni))); // R8
endmodule

bind clash_arbiter clash_arbiter_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slave_mode_i(slave_mode_i),
  .l_cs_ni     (l_cs_ni),
  .l_addr_i    (l_addr_i),
  .r_cs_ni     (r_cs_ni),
  .r_addr_i    (r_addr_i),
  .l_busy_ni   (l_busy_ni),
  .r_busy_ni   (r_busy_ni),
  .l_busy_no   (l_busy_no),
  .r_busy_no   (r_busy_no),
  .l_busy_oe_o (l_busy_oe_o),
  .r_busy_oe_o (r_busy_oe_o),
  .l_wr_block_o(l_wr_block_o),
  .r_wr_block_o(r_wr_block_o)
);

// File: tb/clash_arbiter_tb_top.sv
module clash_arbiter_tb_top;
  localparam int unsigned ADDR_W = 18;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              slave_mode_i = 1'b0;
  logic              l_cs_ni = 1'b1;
  logic [ADDR_W-1:0] l_addr_i = '0;
  logic              r_cs_ni = 1'b1;
  logic [ADDR_W-1:0] r_addr_i = '0;
  logic              l_busy_ni = 1'b1;
  logic              r_busy_ni = 1'b1;
  logic              l_busy_no, r_busy_no, l_busy_oe_o, r_busy_oe_o;
  logic              l_wr_block_o, r_wr_block_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  bit          m_lcs = 1, m_rcs = 1, m_hit = 0, m_lose_r = 1;
  int unsigned m_la = 0, m_ra = 0;
  string       tag = "R9";

  always #10 clk_i = ~clk_i;

  clash_arbiter #(.ADDR_W(ADDR_W)) dut_i (.*);

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit lc, int unsigned la, bit rc, int unsigned ra);
    bit lmov, rmov, hit, onset, lose_r, lbusy, rbusy;
    @(negedge clk_i);
    l_cs_ni = lc; l_addr_i = ADDR_W'(la);
    r_cs_ni = rc; r_addr_i = ADDR_W'(ra);
    #4;
    lmov   = (lc != m_lcs) || (la != m_la);
    rmov   = (rc != m_rcs) || (ra != m_ra);
    hit    = !lc && !rc && (la == ra);
    onset  = hit && (!m_hit || lmov || rmov);
    lose_r = onset ? (rmov || !lmov) : m_lose_r;
    lbusy  = hit && !lose_r;
    rbusy  = hit && lose_r;
    if (!slave_mode_i) begin
      chk(tag, "l_busy_no", l_busy_no, !lbusy);
      chk(tag, "r_busy_no", r_busy_no, !rbusy);
      chk("R6", "oe", l_busy_oe_o && r_busy_oe_o, 1'b1);
      chk("R7", "l_wr_block_o", l_wr_block_o, lbusy);
      chk("R7", "r_wr_block_o", r_wr_block_o, rbusy);
    end else begin
      chk("R8", "busy outs", l_busy_no && r_busy_no, 1'b1);
      chk("R8", "oe", l_busy_oe_o || r_busy_oe_o, 1'b0);
      chk("R8", "l_wr_block_o", l_wr_block_o, !l_busy_ni);
      chk("R8", "r_wr_block_o", r_wr_block_o, !r_busy_ni);
    end
    chk("R4", "both busy", !l_busy_no && !r_busy_no, 1'b0);
    if (rst_ni) begin
      m_lcs = lc; m_la = la; m_rcs = rc; m_ra = ra;
      m_hit = hit; m_lose_r = lose_r;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    // R9: reset with a live collision resolves as a tie
    tag = "R9";
    step(1, 0, 1, 0);
    step(0, 5, 0, 5);
    step(0, 5, 0, 5);
    @(negedge clk_i); rst_ni = 1'b1;
    step(0, 5, 0, 5);
    step(0, 5, 0, 5);
    // R1: deselect and mismatch release
    tag = "R1";
    step(1, 5, 0, 5);
    step(0, 5, 0, 6);
    step(0, 7, 1, 7);
    // R2: right arrives late, then left arrives late
    tag = "R2";
    step(0, 9, 0, 3);
    step(0, 9, 0, 9);
    tag = "R5";
    step(0, 9, 0, 9);
    step(0, 9, 0, 9);
    step(0, 9, 0, 4);
    tag = "R2";
    step(0, 2, 0, 4);
    step(0, 4, 0, 4);
    tag = "R5";
    step(0, 4, 0, 4);
    step(1, 4, 0, 4);
    // R2: late arrival by select rather than address
    tag = "R2";
    step(0, 4, 0, 4);
    // R3: both move in the same cycle
    tag = "R3";
    step(0, 1, 0, 2);
    step(0, 3, 0, 3);
    step(0, 8, 0, 8);
    // R8: follower mode ignores collisions, follows busy inputs
    slave_mode_i = 1'b1;
    tag = "R8";
    for (int i = 0; i < 8; i++) begin
      l_busy_ni = i[0];
      r_busy_ni = i[1];
      step(0, 6, 0, 6 + (i % 2));
    end
    l_busy_ni = 1'b1; r_busy_ni = 1'b1;
    slave_mode_i = 1'b0;
    tag = "R5";
    step(0, 6, 0, 6);
    step(0, 6, 0, 6);
    // random traffic in a narrow window
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      bit lc, rc;
      int unsigned la, ra;
      lc = ($urandom_range(0, 7) == 0);
      rc = ($urandom_range(0, 7) == 0);
      la = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 3) : m_la;
      ra = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 3) : m_ra;
      if (i % 500 == 250) slave_mode_i = ~slave_mode_i;
      l_busy_ni = $urandom_range(0, 1);
      r_busy_ni = $urandom_range(0, 1);
      step(lc, la, rc, ra);
    end
    summary();
  end
endmodule